// File: doc/BRIEF.md
# Power-Down Retention Mode Unlock Detector

This block sits on the device side of an asynchronous memory interface and watches the completed accesses one at a time. It looks for a six-access unlock pattern. The pattern starts with a read from the highest word address, and the data that read returns becomes the reference. Two writes to the same address must echo that reference. Two more writes to that address follow, and their data does not matter. The last access is a read, and its address is the key that chooses how much of the array keeps its contents while the part is powered down.

The interface logic raises a single-cycle event for each finished access, with a read/write flag, the word address and the data word on the bus. It holds a standby level while the chip is deselected between accesses. Each access in the pattern must be separated from the previous one by standby. The detector reports the selected retention mode. For each write it also reports whether the array should commit the write as a normal write or drop it.

Top module: `pdp_detect`

## Requirements
- R1: After reset `mode_o` is 0 (sleep, nothing retained) and `wr_normal_o`, `wr_supp_o` and `key_err_o` are low.
- R2: A complete pattern sets `mode_o` in the cycle after its sixth access, using this key table: read of 17FFFFh gives 1 (4M-bit partial, words 00000h–3FFFFh kept), 0FFFFFh gives 2 (8M-bit partial, words 00000h–7FFFFh kept), 1FFFFFh gives 0 (sleep). The encoding 3 never appears.
- R3: Accesses 2 and 3 must be writes to 1FFFFFh whose data equals the data returned by access 1. A write with other data cancels the pattern, so a later sixth-read key has no effect.
- R4: Accesses 4 and 5 must be writes to 1FFFFFh, and any data value is accepted.
- R5: A write in position 2 or 3 to any other address cancels the pattern and is reported with a one-cycle `wr_normal_o` pulse. Every write outside positions 4 and 5 is reported the same way.
- R6: A write in position 4 or 5 gets a one-cycle `wr_supp_o` pulse and no `wr_normal_o` pulse, whether it continues the pattern or cancels it by going to another address.
- R7: If an access arrives without a cycle of `standby` since the previous access, detection restarts, and that access is judged as if no pattern were in progress.
- R8: A sixth read whose address matches none of the three keys leaves `mode_o` unchanged and gives a one-cycle `key_err_o` pulse.
- R9: A read from 1FFFFFh anywhere before position 6 restarts the pattern at position 1 and takes its data as the new reference.
- R10: All outputs are registered. A pulse appears in the clock cycle after the access event and lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle event for a completed access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 21 | Word address of the access |
| acc_data | input | 16 | Write data or data returned by the read |
| standby | input | 1 | Chip deselected (between accesses) |
| mode_o | output | 2 | Retention mode: 0 sleep, 1 4M-bit partial, 2 8M-bit partial |
| wr_normal_o | output | 1 | Pulse: last write commits normally |
| wr_supp_o | output | 1 | Pulse: last write is dropped |
| key_err_o | output | 1 | Pulse: sixth read carried an unknown key |

## Verification
Directed patterns run the full unlock once with each of the three keys, so a swapped key decode shows up as a wrong mode. Other directed patterns break the pattern in one way each: a wrong echo value, a wrong address in an early or a late position, a missing standby gap, a restart read partway through, and an unknown key. The early and late address breaks tell the normal-write outcome from the dropped-write outcome. Randomized patterns then inject these faults at random positions with random data and gaps, and a bench-side model of the pattern predicts each output.

// File: rtl/pdp_pkg.sv
`timescale 1ns/1ps
package pdp_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP = 2'd0,
    MODE_P4    = 2'd1,
    MODE_P8    = 2'd2
  } pd_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_GOT1 = 3'd1,
    ST_GOT2 = 3'd2,
    ST_GOT3 = 3'd3,
    ST_GOT4 = 3'd4,
    ST_GOT5 = 3'd5
  } step_t;
endpackage

// File: rtl/pdp_keydec.sv
`timescale 1ns/1ps
module pdp_keydec #(
  parameter int AW = 21
) (
  input  logic [AW-1:0] addr,
  output logic          is_top,
  output logic          is_p4,
  output logic          is_p8
);
  localparam logic [AW-1:0] TOP_ADDR = {AW{1'b1}};
  localparam logic [AW-1:0] P4_KEY   = TOP_ADDR & ~(AW'(1) << (AW-2));
  localparam logic [AW-1:0] P8_KEY   = TOP_ADDR & ~(AW'(1) << (AW-1));

  always_comb begin
    is_top = (addr == TOP_ADDR);
    is_p4  = (addr == P4_KEY);
    is_p8  = (addr == P8_KEY);
  end
endmodule

// File: rtl/pdp_gap.sv
`timescale 1ns/1ps
module pdp_gap (
  input  logic clk,
  input  logic rst,
  input  logic acc_valid,
  input  logic standby,
  output logic gap_ok
);
  always_ff @(posedge clk) begin
    if (rst)            gap_ok <= 1'b1;
    else if (acc_valid) gap_ok <= 1'b0;
    else if (standby)   gap_ok <= 1'b1;
  end
endmodule

// File: rtl/pdp_seq.sv
`timescale 1ns/1ps
module pdp_seq
  import pdp_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [DW-1:0] acc_data,
  input  logic          gap_ok,
  input  logic          is_top,
  input  logic          is_p4,
  input  logic          is_p8,
  output pd_mode_t      mode_q,
  output logic          norm_q,
  output logic          supp_q,
  output logic          err_q
);
  step_t         st_q, st_n, eff;
  logic [DW-1:0] ref_q, ref_n;
  pd_mode_t      mode_n;
  logic          norm_n, supp_n, err_n;

  always_comb begin
    eff    = gap_ok ? st_q : ST_IDLE;
    st_n   = st_q;
    ref_n  = ref_q;
    mode_n = mode_q;
    norm_n = 1'b0;
    supp_n = 1'b0;
    err_n  = 1'b0;
    if (acc_valid) begin
      st_n = ST_IDLE;
      if (!acc_write) begin
        if (eff == ST_GOT5) begin
          if (is_top)     mode_n = MODE_SLEEP;
          else if (is_p4) mode_n = MODE_P4;
          else if (is_p8) mode_n = MODE_P8;
          else            err_n  = 1'b1;
        end else if (is_top) begin
          st_n  = ST_GOT1;
          ref_n = acc_data;
        end
      end else begin
        case (eff)
          ST_GOT1, ST_GOT2: begin
            norm_n = 1'b1;
            if (is_top && acc_data == ref_q) st_n = step_t'(eff + 3'd1);
          end
          ST_GOT3, ST_GOT4: begin
            supp_n = 1'b1;
            if (is_top) st_n = step_t'(eff + 3'd1);
          end
          default: norm_n = 1'b1;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      ref_q  <= '0;
      mode_q <= MODE_SLEEP;
      norm_q <= 1'b0;
      supp_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ref_q  <= ref_n;
      mode_q <= mode_n;
      norm_q <= norm_n;
      supp_q <= supp_n;
      err_q  <= err_n;
    end
  end

  assert_mode_legal_R2: assert property (@(posedge clk) disable iff (rst)
    mode_q != 2'd3);
  assert_mode_only_on_read_R2: assert property (@(posedge clk) disable iff (rst)
    (mode_q != $past(mode_q)) |-> $past(acc_valid && !acc_write && gap_ok));
  assert_err_keeps_mode_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $stable(mode_q));
  assert_err_from_read_R8: assert property (@(posedge clk) disable iff (rst)
    err_q |-> $past(acc_valid && !acc_write));
  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(norm_q && supp_q));
  assert_flag_from_write_R10: assert property (@(posedge clk) disable iff (rst)
    (norm_q || supp_q) |-> $past(acc_valid && acc_write));
  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (rst)
    (norm_q || supp_q || err_q) |=> !(err_q && $past(err_q)));
endmodule

// File: rtl/pdp_detect.sv
`timescale 1ns/1ps
module pdp_detect #(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_data,
  input  logic          standby,
  output logic [1:0]    mode_o,
  output logic          wr_normal_o,
  output logic          wr_supp_o,
  output logic          key_err_o
);
  import pdp_pkg::*;

  logic     is_top, is_p4, is_p8, gap_ok;
  pd_mode_t mode_q;

  pdp_keydec #(.AW(AW)) u_dec (
    .addr   (acc_addr),
    .is_top (is_top),
    .is_p4  (is_p4),
    .is_p8  (is_p8)
  );

  pdp_gap u_gap (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .standby   (standby),
    .gap_ok    (gap_ok)
  );

  pdp_seq #(.DW(DW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_data  (acc_data),
    .gap_ok    (gap_ok),
    .is_top    (is_top),
    .is_p4     (is_p4),
    .is_p8     (is_p8),
    .mode_q    (mode_q),
    .norm_q    (wr_normal_o),
    .supp_q    (wr_supp_o),
    .err_q     (key_err_o)
  );

  assign mode_o = mode_q;
endmodule

// File: tb/sim_pdp_detect.sv
`timescale 1ns/1ps
module sim_pdp_detect;
  localparam logic [20:0] TOP = 21'h1FFFFF;
  localparam logic [20:0] KP4 = 21'h17FFFF;
  localparam logic [20:0] KP8 = 21'h0FFFFF;

  logic        clk = 0, rst = 1;
  logic        acc_valid = 0, acc_write = 0, standby = 0;
  logic [20:0] acc_addr = '0;
  logic [15:0] acc_data = '0;
  logic [1:0]  mode_o;
  logic        wr_normal_o, wr_supp_o, key_err_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  int          m_step = 0;
  logic [15:0] m_ref = '0;
  logic [1:0]  m_mode = 2'd0;
  bit          m_gap = 1;

  always #4 clk = ~clk;

  pdp_detect u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_data(acc_data), .standby(standby),
    .mode_o(mode_o), .wr_normal_o(wr_normal_o), .wr_supp_o(wr_supp_o),
    .key_err_o(key_err_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // one access, model prediction, check of the registered outputs
  task automatic acc(input bit w, input logic [20:0] a, input logic [15:0] d,
                     input bit gap_after, input string req);
    int eff, nxt;
    bit e_norm, e_supp, e_err;
    eff = m_gap ? m_step : 0;
    nxt = 0; e_norm = 0; e_supp = 0; e_err = 0;
    if (!w) begin
      if (eff == 5) begin
        if (a == TOP)      m_mode = 2'd0;
        else if (a == KP4) m_mode = 2'd1;
        else if (a == KP8) m_mode = 2'd2;
        else               e_err = 1;
      end else if (a == TOP) begin
        nxt = 1; m_ref = d;
      end
    end else if (eff == 1 || eff == 2) begin
      e_norm = 1;
      if (a == TOP && d == m_ref) nxt = eff + 1;
    end else if (eff == 3 || eff == 4) begin
      e_supp = 1;
      if (a == TOP) nxt = eff + 1;
    end else e_norm = 1;
    m_step = nxt; m_gap = 0;
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_addr = a; acc_data = d;
    @(negedge clk);
    acc_valid = 0;
    acc_addr = 21'($urandom); acc_data = 16'($urandom); acc_write = 1'($urandom);
    chk(req, "mode", int'(mode_o), int'(m_mode));
    chk(req, "wr_normal", int'(wr_normal_o), int'(e_norm));
    chk(req, "wr_supp", int'(wr_supp_o), int'(e_supp));
    chk(req, "key_err", int'(key_err_o), int'(e_err));
    if (gap_after) begin
      standby = 1;
      @(negedge clk);
      standby = 0;
      chk("R10", "pulse width", int'(wr_normal_o | wr_supp_o | key_err_o), 0);
      m_gap = 1;
    end
  endtask

  task automatic full(input logic [15:0] rd, input logic [20:0] key, input string req);
    acc(0, TOP, rd, 1, req);
    acc(1, TOP, rd, 1, req);
    acc(1, TOP, rd, 1, req);
    acc(1, TOP, 16'($urandom), 1, req);
    acc(1, TOP, 16'($urandom), 1, req);
    acc(0, key, 16'($urandom), 1, req);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    report();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    chk("R1", "reset mode", int'(mode_o), 0);
    chk("R1", "reset flags", int'({wr_normal_o, wr_supp_o, key_err_o}), 0);
    rst = 0;
    @(negedge clk);
    chk("R1", "mode after release", int'(mode_o), 0);

    full(16'hA55A, KP4, "R2");
    chk("R2", "p4 mode", int'(mode_o), 1);
    full(16'h0001, KP8, "R4");
    chk("R2", "p8 mode", int'(mode_o), 2);
    full(16'hFFFF, TOP, "R2");
    chk("R2", "sleep mode", int'(mode_o), 0);

    // R3: wrong echo data at access 3
    acc(0, TOP, 16'h1234, 1, "R3");
    acc(1, TOP, 16'h1234, 1, "R3");
    acc(1, TOP, 16'h1235, 1, "R3");
    acc(1, TOP, 16'h0, 1, "R3");
    acc(1, TOP, 16'h0, 1, "R3");
    acc(0, KP8, 16'h0, 1, "R3");
    chk("R3", "mode kept", int'(mode_o), 0);

    // R5: wrong address at access 2
    acc(0, TOP, 16'h5555, 1, "R5");
    acc(1, 21'h000100, 16'h5555, 1, "R5");
    acc(1, TOP, 16'h5555, 1, "R5");
    acc(1, TOP, 16'h5555, 1, "R5");
    acc(0, KP4, 16'h0, 1, "R5");
    chk("R5", "mode kept", int'(mode_o), 0);

    // R6: wrong address at access 5
    acc(0, TOP, 16'h7777, 1, "R6");
    acc(1, TOP, 16'h7777, 1, "R6");
    acc(1, TOP, 16'h7777, 1, "R6");
    acc(1, TOP, 16'h9999, 1, "R6");
    acc(1, 21'h0ABCDE, 16'h9999, 1, "R6");
    acc(0, KP4, 16'h0, 1, "R6");
    chk("R6", "mode kept", int'(mode_o), 0);

    // R7: no standby between access 3 and 4
    acc(0, TOP, 16'h4242, 1, "R7");
    acc(1, TOP, 16'h4242, 1, "R7");
    acc(1, TOP, 16'h4242, 0, "R7");
    acc(1, TOP, 16'h0, 1, "R7");
    acc(1, TOP, 16'h0, 1, "R7");
    acc(0, KP4, 16'h0, 1, "R7");
    chk("R7", "mode kept", int'(mode_o), 0);

    // R8: unknown key
    full(16'h3C3C, KP8, "R8");
    full(16'h3C3C, 21'h000000, "R8");
    chk("R8", "mode kept after bad key", int'(mode_o), 2);

    // R9: restart read at position 4
    acc(0, TOP, 16'h1111, 1, "R9");
    acc(1, TOP, 16'h1111, 1, "R9");
    acc(1, TOP, 16'h1111, 1, "R9");
    acc(0, TOP, 16'h2222, 1, "R9");
    acc(1, TOP, 16'h2222, 1, "R9");
    acc(1, TOP, 16'h2222, 1, "R9");
    acc(1, TOP, 16'h0, 1, "R9");
    acc(1, TOP, 16'h0, 1, "R9");
    acc(0, KP4, 16'h0, 1, "R9");
    chk("R9", "mode after restart", int'(mode_o), 1);

    // R10: plain writes and reads outside the pattern
    acc(1, 21'h000010, 16'hBEEF, 0, "R10");
    acc(1, 21'h000011, 16'hBEEF, 1, "R10");
    acc(0, 21'h000012, 16'h0, 1, "R10");

    // randomized patterns with injected faults
    for (int s = 0; s < 60; s++) begin
      logic [15:0] rd;
      rd = 16'($urandom);
      for (int k = 1; k <= 6; k++) begin
        int r;
        bit g;
        logic [20:0] a;
        logic [15:0] d;
        r = $urandom % 10;
        g = ($urandom % 8) != 0;
        a = TOP; d = rd;
        case (k)
          1: ;
          2, 3: begin
            if (r == 0) a = 21'($urandom);
            if (r == 1) d = rd ^ 16'h0100;
          end
          4, 5: begin
            d = 16'($urandom);
            if (r == 0) a = 21'($urandom);
          end
          default: begin
            case ($urandom % 4)
              0: a = TOP;
              1: a = KP4;
              2: a = KP8;
              default: a = 21'($urandom);
            endcase
          end
        endcase
        acc((k >= 2 && k <= 5), a, d, g, "R2");
      end
    end
    report();
  end
endmodule